// File: doc/BRIEF.md
# Multi-source PHY reset sequencer

This block takes a transceiver-style device through reset. Three sources can start a reset: the active-low external reset pin, the power-on path after the supply is reported good, and a self-clearing software reset bit in management control register 0. The pin is synchronised into the reference clock domain. A low pulse on it counts as a reset only after it has stayed low long enough. Once a reset is accepted, the sequencer holds the device in reset and then releases it in two stages.

In the first stage the management port is declared usable after a fixed initialisation count. In the second stage the reset is declared finished, but only after a minimum wait has passed and the transmit and receive line clocks both report valid. The data interface toward the MAC stays closed until then. When the sequence finishes, a single-cycle strobe loads the management registers with their default values.

A 3-bit state code is brought out so the progress of the sequence can be watched at the ports. The power-on hold interval and the minimum clock wait are counter parameters, so they can be shortened for simulation.

Top module: `phy_rst_seq`

## Requirements
- R1: A pin reset is taken only after the synchronised pin has been low for PIN_MIN consecutive reference cycles (default 5). A shorter low pulse leaves mgmt_ready and reset_done unchanged and returns the state code from 1 to 0.
- R2: After the pin goes high again (two-flop synchroniser, then one cycle to leave hold), the sequencer stays INIT_CYC cycles (default 16) in the init state. Only then does mgmt_ready rise. It is low for the whole of hold and init.
- R3: reset_done rises only after the wait state has lasted more than CLK_MIN cycles and both synchronised clock-valid inputs are high. While either input is low, reset_done stays low.
- R4: data_if_en is high only while reset_done is high and both synchronised clock-valid inputs are high. If a clock-valid input drops after completion, data_if_en falls but reset_done stays high.
- R5: After sys_rst_n the sequencer stays in hold until supply_good has been high for POR_HOLD consecutive cycles. If supply_good drops during that time, the count starts again. It then enters init.
- R6: During the power-on hold the reset pin is ignored: the state code stays 2 and the power-on exit time does not move.
- R7: A management write with address 0 and data bit 15 set starts a software reset. It is accepted only while mgmt_ready is high. Writes to other addresses, or with bit 15 clear, change nothing. sw_reset_bit reads 1 from an accepted write until that sequence completes. Pin and power-on resets never set it.
- R8: load_defaults is a one-cycle pulse in the first cycle after the wait state finishes, for every kind of reset.
- R9: A reset request accepted while a sequence is running or finished (a qualified pin reset or a software reset) moves the state to hold on the next edge. mgmt_ready, reset_done and data_if_en fall in that same cycle.
- R10: state_code encodes the state as 0 running, 1 pin qualify, 2 hold, 3 init, 4 wait for clocks.
- R11: While sys_rst_n is low, the state code is 2, with a power-on hold pending, and all status outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| sys_rst_n | input | 1 | Synchronous active-low reset of the sequencer itself |
| supply_good | input | 1 | Supply reported within range |
| pin_rst_n | input | 1 | External active-low reset pin, asynchronous |
| txclk_ok | input | 1 | Transmit clock reported valid, asynchronous |
| rxclk_ok | input | 1 | Receive clock reported valid, asynchronous |
| mgmt_wr | input | 1 | Management register write strobe |
| mgmt_addr | input | ADDR_W | Management register address |
| mgmt_wdata | input | DATA_W | Management write data |
| mgmt_ready | output | 1 | Management port usable |
| reset_done | output | 1 | Reset sequence fully finished |
| data_if_en | output | 1 | Data interface toward the MAC enabled |
| load_defaults | output | 1 | One-cycle strobe to load register defaults |
| sw_reset_bit | output | 1 | Read value of the self-clearing software reset bit |
| state_code | output | 3 | Current sequence state |

## Verification
A wrong state register or counter in this block shows at the ports within one cycle. The state code is registered, every status output is decoded from it, and the bench model compares all of them on every falling edge. An init count that is off by one moves the rise of mgmt_ready by exactly one cycle, which the directed check at 18 and 19 cycles after the pin is released catches. A pin qualifier with the wrong threshold shows up as a lost or extra fall of reset_done for a 4-cycle or 5-cycle pulse. A software bit that decodes the wrong field leaves the state code unchanged where it should be 2, or changes it where it should stay.

// File: rtl/phy_rst_seq_pkg.sv
// Shared types for the reset sequencer.
// Assumes: the state encoding is visible at the top port and is relied on by users.
package phy_rst_seq_pkg;
    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_QUAL = 3'd1,
        ST_HOLD = 3'd2,
        ST_INIT = 3'd3,
        ST_WAIT = 3'd4
    } seq_state_t;
endpackage

// File: rtl/phy_rst_sync.sv
// Two-flop synchroniser for a vector of independent asynchronous levels.
// Assumes: each bit is a slow level; no bus coherence is needed between bits.
module phy_rst_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] mid;

    // Two register stages into the clk domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid <= RST_VAL;
            q   <= RST_VAL;
        end else begin
            mid <= d;
            q   <= mid;
        end
    end
endmodule

// File: rtl/phy_rst_pinqual.sv
// Pin pulse-width qualifier: raises hw_req in the cycle in which the synchronised
// pin has been low for PIN_MIN consecutive cycles. It is held cleared while ignore is high.
// Assumes: pin_s is already synchronous; PIN_MIN >= 2.
module phy_rst_pinqual #(
    parameter int PIN_MIN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic ignore,
    output logic hw_req
);
    localparam int LW = $clog2(PIN_MIN + 1);
    localparam logic [LW-1:0] LOW_LAST = LW'(PIN_MIN - 1);
    localparam logic [LW-1:0] LOW_SAT  = LW'(PIN_MIN);

    logic [LW-1:0] low_cnt;

    // Count consecutive low cycles, saturating so one pulse gives one request
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (ignore || pin_s)
            low_cnt <= '0;
        else if (low_cnt != LOW_SAT)
            low_cnt <= low_cnt + 1'b1;
    end

    // Request on the qualifying cycle only
    always_comb hw_req = !ignore && !pin_s && (low_cnt == LOW_LAST);

    // R1: a request is preceded by a low pin in the previous cycle
    a_r1_low_before_req: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_req && low_cnt != '0) |-> $past(!pin_s));
endmodule

// File: rtl/phy_rst_seq.sv
// Reset sequencer top. It merges power-on, pin and software reset requests, holds
// reset, then releases in two stages: management ready after an init count, and
// completion after a minimum wait once both line clocks are valid.
// Assumes: clk is the free-running reference clock; sys_rst_n is synchronous.
module phy_rst_seq
    import phy_rst_seq_pkg::*;
#(
    parameter int PIN_MIN   = 5,
    parameter int INIT_CYC  = 16,
    parameter int POR_HOLD  = 500,
    parameter int CLK_MIN   = 1325000,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int CTRL_ADDR = 0,
    parameter int SW_BIT    = 15
) (
    input  logic              clk,
    input  logic              sys_rst_n,
    input  logic              supply_good,
    input  logic              pin_rst_n,
    input  logic              txclk_ok,
    input  logic              rxclk_ok,
    input  logic              mgmt_wr,
    input  logic [ADDR_W-1:0] mgmt_addr,
    input  logic [DATA_W-1:0] mgmt_wdata,
    output logic              mgmt_ready,
    output logic              reset_done,
    output logic              data_if_en,
    output logic              load_defaults,
    output logic              sw_reset_bit,
    output logic [2:0]        state_code
);
    localparam int CNT_MAX = (POR_HOLD > INIT_CYC) ?
                             ((POR_HOLD > CLK_MIN) ? POR_HOLD : CLK_MIN) :
                             ((INIT_CYC > CLK_MIN) ? INIT_CYC : CLK_MIN);
    localparam int CW = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] POR_LAST  = CW'(POR_HOLD - 1);
    localparam logic [CW-1:0] INIT_LAST = CW'(INIT_CYC - 1);
    localparam logic [CW-1:0] WAIT_MIN  = CW'(CLK_MIN);

    seq_state_t     state;
    logic [CW-1:0]  cnt;
    logic           por_active;
    logic           load_q;
    logic           sw_bit;
    logic           pin_s, tx_s, rx_s;
    logic           hw_req;
    logic           sw_req;
    logic [2:0]     sync_q;

    phy_rst_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (sys_rst_n),
        .d     ({pin_rst_n, txclk_ok, rxclk_ok}),
        .q     (sync_q)
    );

    // Split the synchronised levels
    always_comb {pin_s, tx_s, rx_s} = sync_q;

    phy_rst_pinqual #(.PIN_MIN(PIN_MIN)) u_pinqual (
        .clk    (clk),
        .rst_n  (sys_rst_n),
        .pin_s  (pin_s),
        .ignore (por_active),
        .hw_req (hw_req)
    );

    // Decode a software reset write to the control register
    always_comb sw_req = mgmt_wr && (mgmt_addr == ADDR_W'(CTRL_ADDR)) && mgmt_wdata[SW_BIT];

    // Stage outputs decoded from the registered state
    always_comb begin
        mgmt_ready = (state == ST_WAIT) || (state == ST_RUN) || (state == ST_QUAL);
        reset_done = (state == ST_RUN) || (state == ST_QUAL);
        data_if_en = reset_done && tx_s && rx_s;
    end

    // Sequence state, shared counter, power-on flag, load strobe and software bit
    always_ff @(posedge clk) begin
        if (!sys_rst_n) begin
            state      <= ST_HOLD;
            cnt        <= '0;
            por_active <= 1'b1;
            load_q     <= 1'b0;
            sw_bit     <= 1'b0;
        end else begin
            load_q <= 1'b0;
            if (por_active) begin
                sw_bit <= 1'b0;
                if (!supply_good) begin
                    cnt <= '0;
                end else if (cnt == POR_LAST) begin
                    por_active <= 1'b0;
                    state      <= ST_INIT;
                    cnt        <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (hw_req) begin
                state  <= ST_HOLD;
                cnt    <= '0;
                sw_bit <= 1'b0;
            end else if (sw_req && mgmt_ready) begin
                state  <= ST_HOLD;
                cnt    <= '0;
                sw_bit <= 1'b1;
            end else begin
                case (state)
                    ST_RUN:  if (!pin_s) state <= ST_QUAL;
                    ST_QUAL: if (pin_s)  state <= ST_RUN;
                    ST_HOLD: if (pin_s) begin
                        state <= ST_INIT;
                        cnt   <= '0;
                    end
                    ST_INIT: if (cnt == INIT_LAST) begin
                        state <= ST_WAIT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                    ST_WAIT: begin
                        if (cnt != WAIT_MIN)
                            cnt <= cnt + 1'b1;
                        if ((cnt == WAIT_MIN) && tx_s && rx_s) begin
                            state  <= ST_RUN;
                            load_q <= 1'b1;
                            sw_bit <= 1'b0;
                        end
                    end
                    default: state <= ST_HOLD;
                endcase
            end
        end
    end

    // Drive the registered outputs
    always_comb begin
        load_defaults = load_q;
        sw_reset_bit  = sw_bit;
        state_code    = state;
    end

    // R6: the power-on hold keeps the state in hold whatever the pin does
    a_r6_por_holds: assert property (@(posedge clk) disable iff (!sys_rst_n)
        por_active |-> state == ST_HOLD);

    // R8: load strobe lasts one cycle
    a_r8_load_single: assert property (@(posedge clk) disable iff (!sys_rst_n)
        load_defaults |=> !load_defaults);

    // R8: load strobe only on leaving the wait state
    a_r8_load_on_entry: assert property (@(posedge clk) disable iff (!sys_rst_n)
        load_defaults |-> (state == ST_RUN) && ($past(state) == ST_WAIT));

    // R3: completion only after both clocks were seen valid
    a_r3_done_needs_clocks: assert property (@(posedge clk) disable iff (!sys_rst_n)
        $rose(reset_done) |-> $past(tx_s && rx_s));

    // R7: the software bit is set only by an accepted management write
    a_r7_swbit_source: assert property (@(posedge clk) disable iff (!sys_rst_n)
        $rose(sw_bit) |-> $past(mgmt_wr && mgmt_ready));

    // R9: a qualified pin request restarts the sequence in hold
    a_r9_restart_hold: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (hw_req && !por_active) |=> (state == ST_HOLD) && !mgmt_ready);
endmodule

// File: tb/tb_phy_rst_seq.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module tb_phy_rst_seq;
    localparam int PIN_MIN  = 5;
    localparam int INIT_CYC = 16;
    localparam int POR_HOLD = 20;
    localparam int CLK_MIN  = 30;

    logic        clk = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        supply_good = 1'b0;
    logic        pin_rst_n = 1'b1;
    logic        txclk_ok = 1'b0;
    logic        rxclk_ok = 1'b0;
    logic        mgmt_wr = 1'b0;
    logic [4:0]  mgmt_addr = '0;
    logic [15:0] mgmt_wdata = '0;
    logic        mgmt_ready, reset_done, data_if_en, load_defaults, sw_reset_bit;
    logic [2:0]  state_code;

    int tests = 0;
    int fails = 0;
    bit cmp_en = 1'b0;

    always #4 clk = ~clk;

    phy_rst_seq #(
        .PIN_MIN(PIN_MIN), .INIT_CYC(INIT_CYC),
        .POR_HOLD(POR_HOLD), .CLK_MIN(CLK_MIN)
    ) dut (
        .clk(clk), .sys_rst_n(sys_rst_n), .supply_good(supply_good),
        .pin_rst_n(pin_rst_n), .txclk_ok(txclk_ok), .rxclk_ok(rxclk_ok),
        .mgmt_wr(mgmt_wr), .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata),
        .mgmt_ready(mgmt_ready), .reset_done(reset_done), .data_if_en(data_if_en),
        .load_defaults(load_defaults), .sw_reset_bit(sw_reset_bit),
        .state_code(state_code)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference model: plain integers and delay queues
    int m_state, m_cnt, m_low;
    bit m_por, m_ld, m_sw, m_ts, m_rs;
    bit pin_line[$], tx_line[$], rx_line[$];

    always @(posedge clk) begin
        bit ps, ts, rs, go_hw, go_sw, rdy, old_por;
        if (!sys_rst_n) begin
            m_state = 2; m_cnt = 0; m_low = 0; m_por = 1; m_ld = 0; m_sw = 0;
            pin_line = '{1'b1, 1'b1}; tx_line = '{1'b0, 1'b0}; rx_line = '{1'b0, 1'b0};
            m_ts = 0; m_rs = 0;
            cmp_en = 1'b1;
        end else begin
            ps = pin_line[1]; ts = tx_line[1]; rs = rx_line[1];
            old_por = m_por;
            rdy = (m_state == 4) || (m_state == 0) || (m_state == 1);
            go_hw = !m_por && !ps && (m_low == PIN_MIN - 1);
            go_sw = mgmt_wr && (mgmt_addr == 0) && mgmt_wdata[15];
            m_ld = 0;
            if (m_por) begin
                m_sw = 0;
                if (!supply_good) m_cnt = 0;
                else if (m_cnt == POR_HOLD - 1) begin m_por = 0; m_state = 3; m_cnt = 0; end
                else m_cnt++;
            end else if (go_hw) begin
                m_state = 2; m_cnt = 0; m_sw = 0;
            end else if (go_sw && rdy) begin
                m_state = 2; m_cnt = 0; m_sw = 1;
            end else begin
                case (m_state)
                    0: if (!ps) m_state = 1;
                    1: if (ps) m_state = 0;
                    2: if (ps) begin m_state = 3; m_cnt = 0; end
                    3: if (m_cnt == INIT_CYC - 1) begin m_state = 4; m_cnt = 0; end
                       else m_cnt++;
                    4: begin
                        if (m_cnt == CLK_MIN && ts && rs) begin
                            m_state = 0; m_ld = 1; m_sw = 0;
                        end
                        if (m_cnt != CLK_MIN) m_cnt++;
                    end
                    default: m_state = 2;
                endcase
            end
            if (old_por || ps) m_low = 0;
            else if (m_low < PIN_MIN) m_low++;
            pin_line.push_front(pin_rst_n); void'(pin_line.pop_back());
            tx_line.push_front(txclk_ok);   void'(tx_line.pop_back());
            rx_line.push_front(rxclk_ok);   void'(rx_line.pop_back());
            m_ts = tx_line[1]; m_rs = rx_line[1];
        end
    end

    // Compare every output with the model away from the active edge
    always @(negedge clk) begin
        bit e_rdy, e_done, e_if;
        if (cmp_en) begin
            e_rdy  = (m_state == 4) || (m_state == 0) || (m_state == 1);
            e_done = (m_state == 0) || (m_state == 1);
            e_if   = e_done && m_ts && m_rs;
            check(mgmt_ready == e_rdy, "R2", "model mgmt_ready", mgmt_ready, e_rdy);
            check(reset_done == e_done, "R3", "model reset_done", reset_done, e_done);
            check(data_if_en == e_if, "R4", "model data_if_en", data_if_en, e_if);
            check(load_defaults == m_ld, "R8", "model load_defaults", load_defaults, m_ld);
            check(sw_reset_bit == m_sw, "R7", "model sw_reset_bit", sw_reset_bit, m_sw);
            check(int'(state_code) == m_state, "R10", "model state_code", state_code, m_state);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mwrite(input logic [4:0] a, input logic [15:0] d);
        mgmt_addr = a; mgmt_wdata = d; mgmt_wr = 1'b1;
        tick(1);
        mgmt_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        tick(3);
        // R11: reset state
        check(state_code == 3'd2, "R11", "state in reset", state_code, 2);
        check(!mgmt_ready && !reset_done && !load_defaults && !sw_reset_bit && !data_if_en,
              "R11", "outputs in reset", mgmt_ready, 0);
        sys_rst_n = 1'b1;
        tick(10);
        check(state_code == 3'd2, "R5", "hold without supply", state_code, 2);
        // R5: supply drop restarts the count
        supply_good = 1'b1; tick(10);
        supply_good = 1'b0; tick(1);
        check(state_code == 3'd2, "R5", "hold after supply drop", state_code, 2);
        // R6: pin pulse during power-on hold is ignored
        supply_good = 1'b1; pin_rst_n = 1'b0; tick(8);
        pin_rst_n = 1'b1; tick(11);
        check(state_code == 3'd2, "R6", "still power-on hold", state_code, 2);
        tick(1);
        check(state_code == 3'd3, "R6", "power-on exit on time", state_code, 3);
        tick(16);
        check(state_code == 3'd4 && mgmt_ready, "R2", "ready after init", state_code, 4);
        // R3: no completion while clocks invalid
        tick(40);
        check(!reset_done && !data_if_en, "R3", "no done without clocks", reset_done, 0);
        txclk_ok = 1'b1; tick(5);
        check(!reset_done, "R3", "no done with tx only", reset_done, 0);
        rxclk_ok = 1'b1; tick(2);
        check(!reset_done, "R3", "done waits for sync", reset_done, 0);
        tick(1);
        check(reset_done && load_defaults, "R8", "done with load strobe", load_defaults, 1);
        check(data_if_en, "R4", "data interface open", data_if_en, 1);
        tick(1);
        check(!load_defaults, "R8", "strobe one cycle", load_defaults, 0);
        // R4: clock-valid drop closes the interface only
        txclk_ok = 1'b0; tick(2);
        check(!data_if_en && reset_done, "R4", "if closed, done kept", data_if_en, 0);
        txclk_ok = 1'b1; tick(3);
        // R1: 4-cycle pulse ignored
        pin_rst_n = 1'b0; tick(4); pin_rst_n = 1'b1; tick(1);
        check(state_code == 3'd1 && reset_done, "R1", "qualify, still done", state_code, 1);
        tick(4);
        check(state_code == 3'd0 && reset_done, "R1", "short pulse ignored", state_code, 0);
        // R1 / R9: 5-cycle pulse restarts
        pin_rst_n = 1'b0; tick(5); pin_rst_n = 1'b1; tick(3);
        check(state_code == 3'd3 && !mgmt_ready && !reset_done, "R9", "restart after qualified pulse",
              state_code, 3);
        tick(60);
        check(reset_done, "R1", "done after pin reset", reset_done, 1);
        // R2: exact release timing
        pin_rst_n = 1'b0; tick(12);
        check(state_code == 3'd2, "R2", "held while pin low", state_code, 2);
        pin_rst_n = 1'b1; tick(18);
        check(!mgmt_ready, "R2", "not ready at 18", mgmt_ready, 0);
        tick(1);
        check(mgmt_ready, "R2", "ready at 19", mgmt_ready, 1);
        tick(40);
        check(reset_done && !sw_reset_bit, "R7", "pin reset leaves sw bit clear", sw_reset_bit, 0);
        // R7: writes that must be ignored
        mwrite(5'd1, 16'h8000);
        check(state_code == 3'd0 && !sw_reset_bit, "R7", "other address ignored", state_code, 0);
        mwrite(5'd0, 16'h4000);
        check(state_code == 3'd0 && !sw_reset_bit, "R7", "bit 15 clear ignored", state_code, 0);
        mwrite(5'd0, 16'h8000);
        check(sw_reset_bit && state_code == 3'd2 && !mgmt_ready, "R7", "software reset taken",
              state_code, 2);
        tick(3);
        mwrite(5'd0, 16'h8000);
        check(state_code == 3'd3, "R7", "write during init ignored", state_code, 3);
        tick(20);
        check(state_code == 3'd4 && sw_reset_bit, "R7", "bit set in wait", sw_reset_bit, 1);
        // R9: software reset restarts a running wait
        mwrite(5'd0, 16'h8000);
        check(state_code == 3'd2 && !mgmt_ready, "R9", "restart from wait", state_code, 2);
        tick(60);
        check(reset_done && !sw_reset_bit, "R7", "bit self-clears", sw_reset_bit, 0);
        tick(2);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule